// File: doc/BRIEF.md
# Deblocking Edge Decision Mask Generator

This block decides, for one line of samples that crosses a block boundary, which deblocking filter strength should be applied. It takes eight samples on each side of the edge (p7..p0 on one side and q0..q7 on the other, with p0 and q0 touching the boundary), three 8-bit limits (edge, interior and high-variance), a filter span selector and a bit-depth flag. It returns three mutually exclusive enables (narrow, medium, wide filter) and a high-variance flag that a downstream filter datapath uses to limit how far it adjusts the second sample on each side.

All three limits are expressed on an 8-bit scale and are shifted up to the working bit depth before use. A flatness threshold is derived from the same shift. Two flatness tests run side by side: an inner test on the three samples next to p0 and q0, and an outer test on the four samples beyond those. The outer test only counts when the widest span is selected. A parameter chooses between a registered output, one cycle after the input is offered, and a purely combinational path.

Top module: `deblock_edge_decider`

## Requirements
- R1: The edge, interior and high-variance limits are shifted left by 2 when `deep_12b` is 0 (10-bit samples) and by 4 when `deep_12b` is 1 (12-bit samples) before any comparison.
- R2: The flatness threshold is 4 for 10-bit samples and 16 for 12-bit samples; a difference equal to the threshold still counts as flat.
- R3: The line needs filtering only if each of the six neighbour gaps |p3-p2|, |p2-p1|, |p1-p0|, |q1-q0|, |q2-q1|, |q3-q2| is at most the scaled interior limit.
- R4: The line needs filtering only if 2*|p0-q0| + (|p1-q1| >> 1) is at most the scaled edge limit; this sum is formed without overflow even for full-scale samples.
- R5: `hev_flag` is 1 when |p1-p0| or |q1-q0| exceeds the scaled high-variance limit, independently of the filter decision.
- R6: With `span_sel` = 2 (16-wide), `en_wide` = need & inner-flat & outer-flat, `en_mid` = need & inner-flat & not outer-flat, `en_narrow` = need & not inner-flat; inner flatness compares p1..p3 with p0 and q1..q3 with q0, outer flatness compares p4..p7 with p0 and q4..q7 with q0.
- R7: With `span_sel` = 1 (8-wide), `en_mid` = need & inner-flat, `en_narrow` = need & not inner-flat, and `en_wide` is 0.
- R8: With `span_sel` = 0 (4-wide) or 3 (treated as 4-wide), `en_narrow` = need and the other two enables are 0.
- R9: At most one of `en_narrow`, `en_mid`, `en_wide` is 1 in any cycle.
- R10: With the default registered output, results and `out_valid` appear on the clock edge after the input sampled with `in_valid` high; when `out_valid` is 0 all enables and `hev_flag` are 0, and all outputs are 0 in reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input line is valid this cycle |
| deep_12b | input | 1 | 0: 10-bit samples, 1: 12-bit samples |
| span_sel | input | 2 | 0: 4-wide, 1: 8-wide, 2: 16-wide, 3: as 4-wide |
| lim_edge | input | 8 | Edge limit on an 8-bit scale |
| lim_inner | input | 8 | Interior limit on an 8-bit scale |
| lim_hev | input | 8 | High-variance limit on an 8-bit scale |
| p_side | input | 96 | Samples p0..p7, p_k in bits [12k+11:12k] |
| q_side | input | 96 | Samples q0..q7, q_k in bits [12k+11:12k] |
| out_valid | output | 1 | Outputs valid |
| en_narrow | output | 1 | Apply the narrow filter |
| en_mid | output | 1 | Apply the medium filter |
| en_wide | output | 1 | Apply the wide filter |
| hev_flag | output | 1 | High edge variance detected |

## Verification
The bench sweeps every gap through its scaled limit minus one, equal and plus one, at both bit depths, because a design that compared with the unscaled limit or used a strict inequality would flip the decision exactly there. Flatness is driven at 4, 5, 16 and 17, which separates a correct depth-dependent threshold from a fixed one. Full-scale samples on opposite sides push the edge sum well past 12 bits, so a narrow adder would wrap and wrongly enable filtering. Span code 3 and the outer-only non-flat line catch a selector that enables the wide filter for the wrong widths or ignores the outer test.

// File: rtl/deblock_mask_pkg.sv
package deblock_mask_pkg;

    typedef enum logic [1:0] {
        SPAN_NARROW = 2'd0,
        SPAN_MID    = 2'd1,
        SPAN_WIDE   = 2'd2,
        SPAN_RSVD   = 2'd3
    } span_e;

    typedef struct packed {
        logic vld;
        logic narrow;
        logic mid;
        logic wide;
        logic hev;
    } decide_t;

    localparam int ABS_MAXW = 16;

    // Unsigned distance, one bit wider than the operands.
    function automatic logic [ABS_MAXW:0] abs_gap(input logic [ABS_MAXW-1:0] a,
                                                  input logic [ABS_MAXW-1:0] b);
        return (a >= b) ? {1'b0, a - b} : {1'b0, b - a};
    endfunction

endpackage

// File: rtl/deblock_limit_scale.sv
module deblock_limit_scale #(
    parameter int LIM_W = 8,
    parameter int DW    = 13
) (
    input  logic             deep_12b,
    input  logic [LIM_W-1:0] lim_edge,
    input  logic [LIM_W-1:0] lim_inner,
    input  logic [LIM_W-1:0] lim_hev,
    output logic [DW-1:0]    edge_s,
    output logic [DW-1:0]    inner_s,
    output logic [DW-1:0]    hev_s,
    output logic [DW-1:0]    flat_s
);
    localparam logic [2:0] SH_10B = 3'd2;
    localparam logic [2:0] SH_12B = 3'd4;

    logic [2:0] shift_d;

    always_comb begin
        shift_d = deep_12b ? SH_12B : SH_10B;
        edge_s  = DW'(lim_edge)  << shift_d;
        inner_s = DW'(lim_inner) << shift_d;
        hev_s   = DW'(lim_hev)   << shift_d;
        flat_s  = DW'(1)         << shift_d;
    end

endmodule

// File: rtl/deblock_flat_group.sv
module deblock_flat_group
    import deblock_mask_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int N     = 3,
    parameter int DW    = 13
) (
    input  logic [PIX_W-1:0]   anchor,
    input  logic [N*PIX_W-1:0] samples,
    input  logic [DW-1:0]      flat_s,
    output logic               flat
);
    logic [N-1:0] near_d;

    for (genvar k = 0; k < N; k++) begin : g_cmp
        logic [ABS_MAXW:0] gap;
        assign gap       = abs_gap(ABS_MAXW'(anchor), ABS_MAXW'(samples[k*PIX_W +: PIX_W]));
        assign near_d[k] = (gap <= (ABS_MAXW+1)'(flat_s));
    end

    assign flat = &near_d;

endmodule

// File: rtl/deblock_activity.sv
module deblock_activity
    import deblock_mask_pkg::*;
#(
    parameter int PIX_W = 12,
    parameter int DW    = 13
) (
    input  logic [4*PIX_W-1:0] p_near,
    input  logic [4*PIX_W-1:0] q_near,
    input  logic [DW-1:0]      edge_s,
    input  logic [DW-1:0]      inner_s,
    input  logic [DW-1:0]      hev_s,
    output logic               need,
    output logic               hev
);
    localparam int SW = ABS_MAXW + 3;

    logic [4*PIX_W-1:0] side_bus [2];
    logic [2:0]         inner_ok [2];
    logic [1:0]         steep;
    logic [ABS_MAXW:0]  gap_p0q0;
    logic [ABS_MAXW:0]  gap_p1q1;
    logic [SW-1:0]      edge_sum;

    assign side_bus[0] = p_near;
    assign side_bus[1] = q_near;

    for (genvar s = 0; s < 2; s++) begin : g_side
        for (genvar k = 0; k < 3; k++) begin : g_pair
            logic [ABS_MAXW:0] gap;
            assign gap = abs_gap(ABS_MAXW'(side_bus[s][(k+1)*PIX_W +: PIX_W]),
                                 ABS_MAXW'(side_bus[s][k*PIX_W +: PIX_W]));
            assign inner_ok[s][k] = (gap <= (ABS_MAXW+1)'(inner_s));
            if (k == 0) begin : g_hev
                assign steep[s] = (gap > (ABS_MAXW+1)'(hev_s));
            end
        end
    end

    assign gap_p0q0 = abs_gap(ABS_MAXW'(p_near[PIX_W-1:0]), ABS_MAXW'(q_near[PIX_W-1:0]));
    assign gap_p1q1 = abs_gap(ABS_MAXW'(p_near[2*PIX_W-1:PIX_W]),
                              ABS_MAXW'(q_near[2*PIX_W-1:PIX_W]));
    assign edge_sum = SW'({gap_p0q0, 1'b0}) + SW'(gap_p1q1 >> 1);

    assign need = (&inner_ok[0]) & (&inner_ok[1]) & (edge_sum <= SW'(edge_s));
    assign hev  = |steep;

endmodule

// File: rtl/deblock_edge_decider.sv
module deblock_edge_decider
    import deblock_mask_pkg::*;
#(
    parameter int PIX_W   = 12,
    parameter int LIM_W   = 8,
    parameter int TAPS    = 8,
    parameter int REG_OUT = 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic                  deep_12b,
    input  logic [1:0]            span_sel,
    input  logic [LIM_W-1:0]      lim_edge,
    input  logic [LIM_W-1:0]      lim_inner,
    input  logic [LIM_W-1:0]      lim_hev,
    input  logic [TAPS*PIX_W-1:0] p_side,
    input  logic [TAPS*PIX_W-1:0] q_side,
    output logic                  out_valid,
    output logic                  en_narrow,
    output logic                  en_mid,
    output logic                  en_wide,
    output logic                  hev_flag
);
    localparam int INNER = 4;
    localparam int OUTER = TAPS - INNER;
    localparam int DW    = PIX_W + 1;

    logic [DW-1:0] edge_s, inner_s, hev_s, flat_s;
    logic          need, hev_raw;
    logic [1:0]    flat_in_s, flat_out_s;
    logic          flat_in, flat_out;
    logic [TAPS*PIX_W-1:0] side_bus [2];
    decide_t       dec_d, dec_q;

    deblock_limit_scale #(.LIM_W(LIM_W), .DW(DW)) u_scale (
        .deep_12b (deep_12b),
        .lim_edge (lim_edge),
        .lim_inner(lim_inner),
        .lim_hev  (lim_hev),
        .edge_s   (edge_s),
        .inner_s  (inner_s),
        .hev_s    (hev_s),
        .flat_s   (flat_s)
    );

    deblock_activity #(.PIX_W(PIX_W), .DW(DW)) u_activity (
        .p_near (p_side[INNER*PIX_W-1:0]),
        .q_near (q_side[INNER*PIX_W-1:0]),
        .edge_s (edge_s),
        .inner_s(inner_s),
        .hev_s  (hev_s),
        .need   (need),
        .hev    (hev_raw)
    );

    assign side_bus[0] = p_side;
    assign side_bus[1] = q_side;

    for (genvar s = 0; s < 2; s++) begin : g_flat
        deblock_flat_group #(.PIX_W(PIX_W), .N(INNER-1), .DW(DW)) u_inner (
            .anchor (side_bus[s][PIX_W-1:0]),
            .samples(side_bus[s][INNER*PIX_W-1:PIX_W]),
            .flat_s (flat_s),
            .flat   (flat_in_s[s])
        );
        deblock_flat_group #(.PIX_W(PIX_W), .N(OUTER), .DW(DW)) u_outer (
            .anchor (side_bus[s][PIX_W-1:0]),
            .samples(side_bus[s][TAPS*PIX_W-1:INNER*PIX_W]),
            .flat_s (flat_s),
            .flat   (flat_out_s[s])
        );
    end

    assign flat_in  = &flat_in_s;
    assign flat_out = &flat_out_s;

    always_comb begin
        dec_d     = '0;
        dec_d.vld = in_valid;
        if (in_valid) begin
            dec_d.hev = hev_raw;
            case (span_e'(span_sel))
                SPAN_WIDE: begin
                    dec_d.wide   = need & flat_in & flat_out;
                    dec_d.mid    = need & flat_in & ~flat_out;
                    dec_d.narrow = need & ~flat_in;
                end
                SPAN_MID: begin
                    dec_d.mid    = need & flat_in;
                    dec_d.narrow = need & ~flat_in;
                end
                default: begin
                    dec_d.narrow = need;
                end
            endcase
        end
    end

    if (REG_OUT != 0) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                dec_q <= '0;
            end else begin
                dec_q <= dec_d;
            end
        end
    end else begin : g_comb
        assign dec_q = dec_d;
    end

    assign out_valid = dec_q.vld;
    assign en_narrow = dec_q.narrow;
    assign en_mid    = dec_q.mid;
    assign en_wide   = dec_q.wide;
    assign hev_flag  = dec_q.hev;

endmodule

// File: rtl/deblock_edge_decider_chk.sv
module deblock_edge_decider_chk #(
    parameter int LAT = 1
) (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [1:0] span_sel,
    input logic       out_valid,
    input logic       en_narrow,
    input logic       en_mid,
    input logic       en_wide,
    input logic       hev_flag
);
    // R9
    select_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({en_narrow, en_mid, en_wide}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(en_narrow | en_mid | en_wide | hev_flag));

    if (LAT != 0) begin : g_lat
        // R10
        valid_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |-> (out_valid == $past(in_valid)));

        // R8
        span4_only_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && ($past(span_sel) == 2'd0 || $past(span_sel) == 2'd3))
            |-> (!en_mid && !en_wide));

        // R7
        span8_no_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && $past(span_sel) == 2'd1) |-> !en_wide);
    end else begin : g_nolat
        // R10
        valid_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == in_valid);

        // R8
        span4_only_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && (span_sel == 2'd0 || span_sel == 2'd3)) |-> (!en_mid && !en_wide));

        // R7
        span8_no_wide_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && span_sel == 2'd1) |-> !en_wide);
    end

endmodule

bind deblock_edge_decider deblock_edge_decider_chk #(.LAT(REG_OUT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .span_sel (span_sel),
    .out_valid(out_valid),
    .en_narrow(en_narrow),
    .en_mid   (en_mid),
    .en_wide  (en_wide),
    .hev_flag (hev_flag)
);

// File: tb/deblock_edge_decider_bench.sv
module deblock_edge_decider_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        deep_12b = 1'b0;
    logic [1:0]  span_sel = 2'd0;
    logic [7:0]  lim_edge = 8'd0, lim_inner = 8'd0, lim_hev = 8'd0;
    logic [95:0] p_side = '0, q_side = '0;
    logic        out_valid, en_narrow, en_mid, en_wide, hev_flag;

    int total = 0;
    int bad = 0;
    bit done = 0;

    int pv[8];
    int qv[8];
    int bd, ws, le, li, lh;

    bit    exp_v, exp_n, exp_m, exp_w, exp_h;
    string exp_phase = "R10 reset";

    always #10 clk = ~clk;

    deblock_edge_decider u_deblock_edge_decider (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .deep_12b(deep_12b),
        .span_sel(span_sel), .lim_edge(lim_edge), .lim_inner(lim_inner),
        .lim_hev(lim_hev), .p_side(p_side), .q_side(q_side),
        .out_valid(out_valid), .en_narrow(en_narrow), .en_mid(en_mid),
        .en_wide(en_wide), .hev_flag(hev_flag)
    );

    function automatic int ad(int a, int b);
        return (a > b) ? a - b : b - a;
    endfunction

    // Behavioural reference of the decision rules.
    function automatic void model(input int bdv, input int wsv, input int e, input int i,
                                  input int h, input int pp[8], input int qq[8],
                                  output bit n, output bit m, output bit w, output bit hv);
        int sh, es, is, hs, fs;
        bit fm, f8, fo, wide16, mid8;
        sh = bdv ? 4 : 2;
        es = e << sh; is = i << sh; hs = h << sh; fs = 1 << sh;
        fm = 1;
        for (int k = 0; k < 3; k++) begin
            if (ad(pp[k+1], pp[k]) > is) fm = 0;
            if (ad(qq[k+1], qq[k]) > is) fm = 0;
        end
        if (2 * ad(pp[0], qq[0]) + (ad(pp[1], qq[1]) >> 1) > es) fm = 0;
        hv = (ad(pp[1], pp[0]) > hs) || (ad(qq[1], qq[0]) > hs);
        f8 = 1;
        for (int k = 1; k < 4; k++) if (ad(pp[k], pp[0]) > fs || ad(qq[k], qq[0]) > fs) f8 = 0;
        fo = 1;
        for (int k = 4; k < 8; k++) if (ad(pp[k], pp[0]) > fs || ad(qq[k], qq[0]) > fs) fo = 0;
        wide16 = (wsv == 2);
        mid8   = (wsv == 1);
        w = wide16 && fm && f8 && fo;
        m = fm && f8 && (wide16 ? !fo : mid8);
        n = fm && ((wide16 || mid8) ? !f8 : 1'b1);
    endfunction

    task automatic check(input string ph, input string tag, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s (%s): actual=%0d expected=%0d", tag, ph, act, expv);
        end
    endtask

    task automatic compare_outputs();
        check(exp_phase, "R10 out_valid", out_valid, exp_v);
        check(exp_phase, "R8 en_narrow", en_narrow, exp_n);
        check(exp_phase, "R7 en_mid", en_mid, exp_m);
        check(exp_phase, "R6 en_wide", en_wide, exp_w);
        check(exp_phase, "R5 hev_flag", hev_flag, exp_h);
        check(exp_phase, "R9 exclusive", int'($onehot0({en_narrow, en_mid, en_wide})), 1);
    endtask

    task automatic step(input bit v, input string ph);
        bit n, m, w, hv;
        @(negedge clk);
        compare_outputs();
        in_valid  = v;
        deep_12b  = bd[0];
        span_sel  = 2'(ws);
        lim_edge  = 8'(le);
        lim_inner = 8'(li);
        lim_hev   = 8'(lh);
        for (int k = 0; k < 8; k++) begin
            p_side[k*12 +: 12] = 12'(pv[k]);
            q_side[k*12 +: 12] = 12'(qv[k]);
        end
        if (v) model(bd, ws, le, li, lh, pv, qv, n, m, w, hv);
        else begin n = 0; m = 0; w = 0; hv = 0; end
        exp_v = v; exp_n = n; exp_m = m; exp_w = w; exp_h = hv;
        exp_phase = ph;
    endtask

    task automatic fill(input int base);
        for (int k = 0; k < 8; k++) begin pv[k] = base; qv[k] = base; end
    endtask

    task automatic rand_line(input int spread);
        int maxv, base, qbase, x;
        maxv  = bd ? 4095 : 1023;
        base  = int'($urandom_range(maxv, 0));
        qbase = base + int'($urandom_range(2 * spread, 0)) - spread;
        for (int k = 0; k < 8; k++) begin
            x = base + int'($urandom_range(2 * spread, 0)) - spread;
            pv[k] = (x < 0) ? 0 : (x > maxv ? maxv : x);
            x = qbase + int'($urandom_range(2 * spread, 0)) - spread;
            qv[k] = (x < 0) ? 0 : (x > maxv ? maxv : x);
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin : main
        int d_list[5];
        int spreads[7];
        d_list  = '{0, 4, 5, 16, 17};
        spreads = '{0, 2, 4, 8, 16, 40, 400};
        bd = 0; ws = 0; le = 0; li = 0; lh = 0;
        fill(0);
        exp_v = 0; exp_n = 0; exp_m = 0; exp_w = 0; exp_h = 0;

        // R10: all outputs low in reset
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare_outputs();
        rst_n = 1'b1;

        // R2 / R6 / R7 / R8: inner flatness threshold at both depths and all spans
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 5; a++)
                    for (int c = 0; c < 5; c += 2) begin
                        bd = b; ws = s; le = 255; li = 255; lh = 255;
                        fill(500);
                        for (int k = 1; k < 8; k++) begin
                            pv[k] = 500 + d_list[a];
                            qv[k] = 500 + d_list[c];
                        end
                        step(1'b1, "R2 inner flat sweep");
                    end

        // R6: outer-only deviation, inner samples equal
        for (int b = 0; b < 2; b++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 5; a++) begin
                    bd = b; ws = s; le = 255; li = 255; lh = 255;
                    fill(600);
                    for (int k = 4; k < 8; k++) pv[k] = 600 + d_list[a];
                    qv[7] = 600 - d_list[4 - a];
                    step(1'b1, "R6 outer flat sweep");
                end

        // R1 / R3: interior gaps around the scaled interior limit
        for (int b = 0; b < 2; b++)
            for (int dd = -1; dd <= 1; dd++) begin
                bd = b; ws = 2; le = 255; li = 5; lh = 255;
                fill(500);
                pv[3] = 500 + (5 << (b ? 4 : 2)) + dd;
                step(1'b1, "R3 interior p3 gap");
                fill(500);
                qv[2] = 500 + (5 << (b ? 4 : 2)) + dd;
                qv[3] = qv[2];
                step(1'b1, "R1 interior q2 gap");
            end

        // R4: edge sum around the scaled edge limit
        for (int b = 0; b < 2; b++)
            for (int d = 0; d <= 40; d++) begin
                bd = b; ws = 1; le = 20 >> (b ? 2 : 0); li = 255; lh = 255;
                fill(500);
                for (int k = 0; k < 8; k++) qv[k] = 500 + d;
                step(1'b1, "R4 edge sum");
            end

        // R5: high-variance threshold on each side
        for (int b = 0; b < 2; b++)
            for (int dd = -1; dd <= 1; dd++) begin
                bd = b; ws = 0; le = 255; li = 255; lh = 3;
                fill(500);
                qv[1] = 500 + (3 << (b ? 4 : 2)) + dd;
                step(1'b1, "R5 hev q side");
                fill(500);
                pv[1] = 500 - (3 << (b ? 4 : 2)) - dd;
                step(1'b1, "R5 hev p side");
            end

        // R4: full-scale step across the edge must not wrap
        bd = 1; ws = 2; le = 255; li = 255; lh = 255;
        for (int k = 0; k < 8; k++) begin pv[k] = 4095; qv[k] = 0; end
        step(1'b1, "R4 full scale");
        for (int k = 0; k < 8; k++) begin pv[k] = 0; qv[k] = 4095; end
        qv[1] = 0;
        step(1'b1, "R4 full scale mixed");

        // R10: idle cycles carry no enables
        step(1'b0, "R10 idle");
        step(1'b0, "R10 idle");

        // Random mixture of all rules with valid gaps
        for (int it = 0; it < 1500; it++) begin
            bd = int'($urandom_range(1, 0));
            ws = int'($urandom_range(3, 0));
            le = ($urandom_range(3, 0) == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(30, 0));
            li = ($urandom_range(3, 0) == 0) ? int'($urandom_range(255, 0)) : int'($urandom_range(12, 0));
            lh = int'($urandom_range(8, 0));
            rand_line(spreads[$urandom_range(6, 0)]);
            step($urandom_range(4, 0) != 0, "R9 random mix");
        end

        step(1'b0, "R10 flush");
        step(1'b0, "R10 flush");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule